// File: doc/BRIEF.md
# CAN Controller Mode-Control Register

This block holds the configuration word that places a CAN controller in one of three operating modes: running, frozen, or switched off. It has three writable control fields: a switch-off request, a freeze permission and a stop request. It also watches a debug breakpoint input. From these it settles the mode, gates the clock enables of the protocol engine and the message-buffer logic, reports a not-ready status, and opens the write path of the error-counter register only while frozen.

Software reaches the word through a single-cycle register write port. Each write carries a supervisor qualifier. A write that lacks the qualifier changes nothing and raises a one-cycle bus-error pulse. A soft-reset input restores every field to its reset value, except the switch-off request, which it leaves untouched. After a hard reset the controller is frozen, and it stays frozen until software clears the stop request.

Top module: `canmode_ctrl`

## Requirements
- R1: After hard reset the read word is 0x5800_0000: off=0 (bit 31), freeze_en=1 (bit 30), stop=1 (bit 28), not_ready=1 (bit 27). The mode is FREEZE (2'b01), both clock enables are 1, the error-counter write enable is 1 and bus_err is 0.
- R2: A write with wr_sup=1 loads off, freeze_en and stop from wr_data bits 31, 30 and 28 at the next clock edge. All other read bits always read 0.
- R3: While off=1 the mode is OFF (2'b10), both clock enables are 0 and not_ready is 1. The off field takes priority over freeze.
- R4: With off=0 and freeze_en=1, the mode is FREEZE (2'b01) when stop=1 or dbg_brk=1, and not_ready reads 1.
- R5: With off=0 and freeze_en=0, stop and dbg_brk have no effect: the mode is RUN (2'b00) and not_ready reads 0.
- R6: errcnt_wr_en is 1 exactly when the mode is FREEZE.
- R7: soft_rst sets freeze_en and stop to 1 and keeps off unchanged. A write in the same cycle as soft_rst is discarded.
- R8: A write with wr_sup=0 changes no field, and bus_err is 1 for the cycle after it. A supervisor write leaves bus_err at 0.
- R9: Mode, clock enables and not_ready change one clock after the write, soft reset or dbg_brk change that causes them. Releasing dbg_brk with stop=0 returns the controller to RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous soft reset of the register |
| wr_en | input | 1 | Register write strobe |
| wr_sup | input | 1 | Supervisor qualifier of the write |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Current register word |
| dbg_brk | input | 1 | Debug breakpoint request |
| mode | output | 2 | 00 RUN, 01 FREEZE, 10 OFF |
| not_ready | output | 1 | 1 while frozen or off |
| proto_clk_en | output | 1 | Protocol engine clock enable |
| mbuf_clk_en | output | 1 | Message buffer clock enable |
| errcnt_wr_en | output | 1 | Error-counter write permitted |
| bus_err | output | 1 | One-cycle pulse after an unqualified write |

## Verification
Soft reset and a register write can fall in the same clock. The same holds for a write and a breakpoint change. The bench drives a supervisor write together with soft_rst and expects the soft-reset values, with the off field kept. It also drives a non-supervisor write together with soft_rst and expects both the reset fields and the bus-error pulse. For the breakpoint case, the bench writes stop=0 while raising dbg_brk in the same cycle and expects FREEZE. The scoreboard model applies soft reset over the write and judges the mode from the fields and dbg_brk sampled at that edge.

// File: rtl/canmode_pkg.sv
package canmode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN    = 2'b00,
    MODE_FREEZE = 2'b01,
    MODE_OFF    = 2'b10
  } mode_e;

  localparam int POS_OFF    = 31;
  localparam int POS_FRZEN  = 30;
  localparam int POS_STOP   = 28;
  localparam int POS_NRDY   = 27;

  typedef struct packed {
    logic off;
    logic frz_en;
    logic stop;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{off: 1'b0, frz_en: 1'b1, stop: 1'b1};
endpackage

// File: rtl/canmode_rstsync.sv
module canmode_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/canmode_regs.sv
module canmode_regs
  import canmode_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic              wr_sup,
  input  logic [DATA_W-1:0] wr_data,
  output ctl_t              ctl_q,
  output ctl_t              ctl_d,
  output logic              bus_err
);
  logic ctl_ld;
  logic err_d;
  logic unused_wbits;

  assign unused_wbits = ^wr_data;

  // next-state
  always_comb begin
    ctl_d  = ctl_q;
    ctl_ld = 1'b0;
    if (soft_rst) begin
      ctl_d.frz_en = CTL_RESET.frz_en;
      ctl_d.stop   = CTL_RESET.stop;
      ctl_ld       = 1'b1;
    end else if (wr_en && wr_sup) begin
      ctl_d.off    = wr_data[POS_OFF];
      ctl_d.frz_en = wr_data[POS_FRZEN];
      ctl_d.stop   = wr_data[POS_STOP];
      ctl_ld       = 1'b1;
    end
    err_d = wr_en && !wr_sup;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= CTL_RESET;
      bus_err <= 1'b0;
    end else begin
      if (ctl_ld) ctl_q <= ctl_d;
      bus_err <= err_d;
    end
  end
endmodule

// File: rtl/canmode_fsm.sv
module canmode_fsm
  import canmode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctl_t  ctl_d,
  input  logic  dbg_brk,
  output mode_e mode_q,
  output logic  not_ready,
  output logic  proto_clk_en,
  output logic  mbuf_clk_en,
  output logic  errcnt_wr_en
);
  mode_e mode_d;
  logic  nrdy_d;
  logic  cke_d;

  // next-state: off dominates, freeze needs permission
  always_comb begin
    if (ctl_d.off)
      mode_d = MODE_OFF;
    else if (ctl_d.frz_en && (ctl_d.stop || dbg_brk))
      mode_d = MODE_FREEZE;
    else
      mode_d = MODE_RUN;
    nrdy_d = (mode_d != MODE_RUN);
    cke_d  = (mode_d != MODE_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= MODE_FREEZE;
      not_ready    <= 1'b1;
      proto_clk_en <= 1'b1;
      mbuf_clk_en  <= 1'b1;
    end else begin
      mode_q       <= mode_d;
      not_ready    <= nrdy_d;
      proto_clk_en <= cke_d;
      mbuf_clk_en  <= cke_d;
    end
  end

  assign errcnt_wr_en = (mode_q == MODE_FREEZE);
endmodule

// File: rtl/canmode_ctrl.sv
module canmode_ctrl
  import canmode_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic              wr_sup,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dbg_brk,
  output logic [1:0]        mode,
  output logic              not_ready,
  output logic              proto_clk_en,
  output logic              mbuf_clk_en,
  output logic              errcnt_wr_en,
  output logic              bus_err
);
  logic  rst_n_s;
  ctl_t  ctl_q;
  ctl_t  ctl_d;
  mode_e mode_q;

  canmode_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  canmode_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .soft_rst (soft_rst),
    .wr_en    (wr_en),
    .wr_sup   (wr_sup),
    .wr_data  (wr_data),
    .ctl_q    (ctl_q),
    .ctl_d    (ctl_d),
    .bus_err  (bus_err)
  );

  canmode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .ctl_d        (ctl_d),
    .dbg_brk      (dbg_brk),
    .mode_q       (mode_q),
    .not_ready    (not_ready),
    .proto_clk_en (proto_clk_en),
    .mbuf_clk_en  (mbuf_clk_en),
    .errcnt_wr_en (errcnt_wr_en)
  );

  assign mode = mode_q;

  // read word: defined fields only, the rest zero
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      case (i)
        POS_OFF:   rd_data[i] = ctl_q.off;
        POS_FRZEN: rd_data[i] = ctl_q.frz_en;
        POS_STOP:  rd_data[i] = ctl_q.stop;
        POS_NRDY:  rd_data[i] = not_ready;
        default:   rd_data[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/canmode_ctrl_chk.sv
module canmode_ctrl_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              wr_en,
  input logic              wr_sup,
  input logic [DATA_W-1:0] rd_data,
  input logic [1:0]        mode,
  input logic              not_ready,
  input logic              proto_clk_en,
  input logic              mbuf_clk_en,
  input logic              errcnt_wr_en,
  input logic              bus_err
);
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[29] == 1'b0 && rd_data[26:0] == '0);  // R2

  AST_OFF_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31] |-> (mode == 2'b10 && !proto_clk_en && !mbuf_clk_en && not_ready));  // R3

  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[31] && rd_data[30] && rd_data[28]) |-> (mode == 2'b01 && not_ready));  // R4

  AST_NOFRZ_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[31] && !rd_data[30]) |-> (mode == 2'b00 && !not_ready));  // R5

  AST_ERRCNT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    errcnt_wr_en |-> (mode == 2'b01));  // R6

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rd_data[30] && rd_data[28] && rd_data[31] == $past(rd_data[31])));  // R7

  AST_NOSUP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sup && !soft_rst) |=> (bus_err && $stable(rd_data[31:28])));  // R8

  AST_BUSERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(wr_en && !wr_sup));  // R8
endmodule

bind canmode_ctrl canmode_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .soft_rst     (soft_rst),
  .wr_en        (wr_en),
  .wr_sup       (wr_sup),
  .rd_data      (rd_data),
  .mode         (mode),
  .not_ready    (not_ready),
  .proto_clk_en (proto_clk_en),
  .mbuf_clk_en  (mbuf_clk_en),
  .errcnt_wr_en (errcnt_wr_en),
  .bus_err      (bus_err)
);

// File: tb/canmode_ctrl_tb.sv
module canmode_ctrl_tb;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          soft_rst;
  logic          wr_en;
  logic          wr_sup;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic          dbg_brk;
  logic [1:0]    mode;
  logic          not_ready;
  logic          proto_clk_en;
  logic          mbuf_clk_en;
  logic          errcnt_wr_en;
  logic          bus_err;

  always #2 clk = ~clk;  // 250 MHz

  canmode_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .wr_en        (wr_en),
    .wr_sup       (wr_sup),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .dbg_brk      (dbg_brk),
    .mode         (mode),
    .not_ready    (not_ready),
    .proto_clk_en (proto_clk_en),
    .mbuf_clk_en  (mbuf_clk_en),
    .errcnt_wr_en (errcnt_wr_en),
    .bus_err      (bus_err)
  );

  typedef struct {
    logic [DW-1:0] rd;
    logic [1:0]    md;
    logic          nr;
    logic          ckp;
    logic          ckb;
    logic          ewe;
    logic          berr;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  // bench model of the fields
  logic m_off, m_fe, m_stop;

  task automatic step(input logic sr, input logic we, input logic sup,
                      input logic [DW-1:0] d, input logic brk, input string tag);
    exp_t e;
    logic [1:0] md;
    @(negedge clk);
    soft_rst = sr; wr_en = we; wr_sup = sup; wr_data = d; dbg_brk = brk;
    if (sr) begin
      m_fe = 1'b1; m_stop = 1'b1;
    end else if (we && sup) begin
      m_off = d[31]; m_fe = d[30]; m_stop = d[28];
    end
    md = m_off ? 2'b10 : ((m_fe && (m_stop || brk)) ? 2'b01 : 2'b00);
    e.md   = md;
    e.nr   = (md != 2'b00);
    e.ckp  = (md != 2'b10);
    e.ckb  = (md != 2'b10);
    e.ewe  = (md == 2'b01);
    e.berr = we && !sup;
    e.rd   = {m_off, m_fe, 1'b0, m_stop, e.nr, 27'd0};
    e.tag  = tag;
    q.push_back(e);
  endtask

  // monitor: compares one item per clock, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        if (rd_data !== e.rd || mode !== e.md || not_ready !== e.nr ||
            proto_clk_en !== e.ckp || mbuf_clk_en !== e.ckb ||
            errcnt_wr_en !== e.ewe || bus_err !== e.berr) begin
          n_fail++;
          $display("FAIL %s: got rd=%h mode=%b nr=%b ck=%b%b ewe=%b berr=%b exp rd=%h mode=%b nr=%b ck=%b%b ewe=%b berr=%b",
                   e.tag, rd_data, mode, not_ready, proto_clk_en, mbuf_clk_en, errcnt_wr_en, bus_err,
                   e.rd, e.md, e.nr, e.ckp, e.ckb, e.ewe, e.berr);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; wr_en = 1'b0; wr_sup = 1'b0;
    wr_data = '0; dbg_brk = 1'b0;
    m_off = 1'b0; m_fe = 1'b1; m_stop = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    step(0, 0, 0, 32'h0,         0, "R1 reset state");
    step(0, 1, 1, 32'h4000_0000, 0, "R2 clear stop -> run");
    step(0, 0, 0, 32'h0,         1, "R4 R9 breakpoint freezes");
    step(0, 0, 0, 32'h0,         1, "R6 freeze holds");
    step(0, 0, 0, 32'h0,         0, "R9 breakpoint release");
    step(0, 1, 1, 32'h5000_0000, 0, "R4 stop freezes");
    step(0, 1, 1, 32'h1000_0000, 0, "R5 stop without permission");
    step(0, 0, 0, 32'h0,         1, "R5 breakpoint ignored");
    step(0, 1, 1, 32'hFFFF_FFFF, 1, "R2 R3 all ones -> off");
    step(0, 1, 1, 32'hAFFF_FFFF, 0, "R3 off without freeze fields");
    step(1, 0, 0, 32'h0,         0, "R7 soft reset keeps off");
    step(0, 1, 0, 32'h0,         0, "R8 unqualified write ignored");
    step(0, 0, 0, 32'h0,         0, "R8 pulse ends");
    step(0, 1, 1, 32'h4000_0000, 0, "R2 back to run");
    step(1, 1, 1, 32'h8000_0000, 0, "R7 soft reset beats write");
    step(0, 1, 1, 32'h4000_0000, 0, "R6 run no errcnt write");
    step(1, 1, 0, 32'h0,         0, "R7 R8 soft reset with bad write");
    step(0, 1, 1, 32'h4000_0000, 1, "R9 write and breakpoint same cycle");
    step(0, 0, 0, 32'h0,         0, "R9 release to run");
    step(0, 1, 0, 32'h9000_0000, 0, "R8 back-to-back bad write 1");
    step(0, 1, 0, 32'h9000_0000, 0, "R8 back-to-back bad write 2");
    step(0, 0, 0, 32'h0,         0, "R8 idle after");

    @(negedge clk);
    soft_rst = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule